// File: doc/BRIEF.md
# Critical-Band Transform Sequencer

This block is the control half of a critical-band spectral analyser. It steps one shared multiply-accumulate datapath through every band of a frame and produces all the memory addresses that the datapath needs. The memories and the arithmetic sit outside. Each band is a windowed sum over the first N samples of the frame. Cosine terms are symmetric about the middle of the window and sine terms are antisymmetric. Because of this, the datapath consumes one butterfly per cycle: the sample pair (j, N−j) with one cosine word and one sine word. About half the multiplies are saved this way.

The block has two modes. In I/O mode, a stream of load strobes fills the sample RAM one word at a time, and a stream of read requests walks the result RAM. A start strobe switches the block into transform mode. In that mode it runs the bands in ascending order. For each band it issues a first butterfly that holds only the lone sample x[0]. Then it issues converging sample pairs, and a parity-dependent final butterfly. It waits for the datapath pipeline to drain and writes the real and imaginary results to the output RAM. After the last band it flags frame completion and falls back to I/O mode. Per-band window lengths, butterfly counts, parities and coefficient offsets are computed at elaboration from a few parameters.

Top module: `cbseq_top`

## Requirements
- R1: After reset the block is in I/O mode: `busy_o`, `frame_done_o`, every enable and every write strobe are low, and `smp_a_addr_o` and `out_addr_o` are 0.
- R2: In I/O mode each cycle with `ld_valid_i` high asserts `smp_we_o`. `smp_a_addr_o` gives the load address, which counts 0,1,… and wraps from FRAME_LEN−1 (159) to 0. A cycle without the strobe leaves the address unchanged.
- R3: In I/O mode each cycle with `rd_req_i` high asserts `out_rd_o`. `out_addr_o` counts 0,1,… and wraps from 2·NUM_BANDS−1 (41) to 0.
- R4: `start_i` in I/O mode puts the block in transform mode on the next clock edge (`busy_o` high) and clears both I/O counters. Bands then run one at a time in index order 0 to NUM_BANDS−1 (0 to 20), and `band_o` shows the index.
- R5: Window length N of band b is FRAME_LEN (160) for b < FLAT_BANDS (5). Each later band uses floor(previous N · 28 / 33). The band runs N/2+1 butterflies (integer division). `even_o` is 1 when N is even.
- R6: Butterfly j of a band drives `smp_a_addr_o` = j with `smp_a_en_o` high. For j ≥ 1, `smp_b_addr_o` = N−j with `smp_b_en_o` high. At j = 0, and at the final butterfly of an even-N band, `smp_b_en_o` is low and `smp_b_addr_o` is 0.
- R7: Butterfly j drives `cos_addr_o` = base+2j and `sin_addr_o` = base+2j+1 with `coef_en_o` high. Here base is the sum of 2·(N/2+1) over all lower bands, so band 0 starts at 0.
- R8: `band_first_o` is high exactly on butterfly 0 of a band, and `band_last_o` exactly on its final butterfly.
- R9: After the final butterfly of band b, PIPE_LAT (3) cycles pass with no enables. Then `out_we_o` is high for two cycles: first at address 2b with `out_imag_o` = 0, then at 2b+1 with `out_imag_o` = 1. The next band's butterfly 0 follows in the next cycle.
- R10: In the cycle after the imaginary write of the last band, `busy_o` is low and `frame_done_o` is high, for that one cycle only.
- R11: While `busy_o` is high, `ld_valid_i`, `rd_req_i` and `start_i` have no effect. `smp_we_o` and `out_rd_o` stay low, the band order does not restart, and both I/O counters still read 0 in the first I/O cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transform frame (I/O mode only) |
| ld_valid_i | input | 1 | One sample is being loaded this cycle |
| rd_req_i | input | 1 | One result word is being read this cycle |
| busy_o | output | 1 | Transform mode |
| frame_done_o | output | 1 | One-cycle pulse after the last write-back |
| smp_a_addr_o | output | 8 | Load address (I/O) or first sample address j (transform) |
| smp_we_o | output | 1 | Sample RAM write strobe |
| smp_a_en_o | output | 1 | First sample read valid |
| smp_b_addr_o | output | 8 | Second sample address N−j |
| smp_b_en_o | output | 1 | Second sample read valid |
| cos_addr_o | output | 11 | Cosine coefficient address |
| sin_addr_o | output | 11 | Sine coefficient address |
| coef_en_o | output | 1 | Coefficient read valid |
| band_first_o | output | 1 | First butterfly of a band |
| band_last_o | output | 1 | Final butterfly of a band |
| even_o | output | 1 | Current band has an even window length |
| band_o | output | 5 | Current band index |
| out_addr_o | output | 6 | Result RAM address (read in I/O, write in transform) |
| out_we_o | output | 1 | Result write strobe |
| out_imag_o | output | 1 | Result write carries the imaginary part |
| out_rd_o | output | 1 | Result read strobe |

## Verification
Two pairs of functions can fall in one cycle. The first pair is the completion pulse and the first result read. The second pair is the completion pulse and the first load of the next frame. The bench holds `rd_req_i`, `ld_valid_i` and `start_i` high through a whole transform. It expects them to be ignored in every busy cycle. In the single cycle where `frame_done_o` rises, it expects them to be served at address 0. A second frame runs with the side inputs quiet. This shows that band order, coefficient bases and write-back slots do not depend on that traffic.

// File: rtl/cbseq_pkg.sv
package cbseq_pkg;

    typedef enum logic [2:0] {
        M_IO    = 3'd0,
        M_RUN   = 3'd1,
        M_DRAIN = 3'd2,
        M_WRE   = 3'd3,
        M_WIM   = 3'd4
    } mode_e;

    // Window length of a band: flat region, then geometric shrink.
    function automatic int win_len(int band, int frame, int n_flat,
                                   int sh_num, int sh_den);
        int n;
        n = frame;
        for (int i = n_flat; i <= band; i++) begin
            n = (n * sh_num) / sh_den;
        end
        return n;
    endfunction

    // Butterflies per band: lone x[0], converging pairs, parity tail.
    function automatic int bfly_cnt(int n);
        return n / 2 + 1;
    endfunction

    // First coefficient word of a band: two words per butterfly below it.
    function automatic int coef_base(int band, int frame, int n_flat,
                                     int sh_num, int sh_den);
        int s;
        s = 0;
        for (int i = 0; i < band; i++) begin
            s += 2 * bfly_cnt(win_len(i, frame, n_flat, sh_num, sh_den));
        end
        return s;
    endfunction

endpackage

// File: rtl/cbseq_band_table.sv
module cbseq_band_table #(
    parameter int NUM_BANDS  = 21,
    parameter int FRAME_LEN  = 160,
    parameter int FLAT_BANDS = 5,
    parameter int SHRINK_NUM = 28,
    parameter int SHRINK_DEN = 33,
    parameter int BW         = 5,
    parameter int NW         = 8,
    parameter int BFW        = 7,
    parameter int CAW        = 11
) (
    input  logic [BW-1:0]  band_i,
    output logic [NW-1:0]  win_o,
    output logic [BFW-1:0] nbf_o,
    output logic           even_o,
    output logic [CAW-1:0] base_o
);

    logic [NW-1:0]  tbl_win  [NUM_BANDS];
    logic [BFW-1:0] tbl_nbf  [NUM_BANDS];
    logic [CAW-1:0] tbl_base [NUM_BANDS];

    for (genvar g = 0; g < NUM_BANDS; g++) begin : g_row
        localparam int WL = cbseq_pkg::win_len(g, FRAME_LEN, FLAT_BANDS,
                                               SHRINK_NUM, SHRINK_DEN);
        localparam int BF = cbseq_pkg::bfly_cnt(WL);
        localparam int CB = cbseq_pkg::coef_base(g, FRAME_LEN, FLAT_BANDS,
                                                 SHRINK_NUM, SHRINK_DEN);
        assign tbl_win[g]  = NW'(WL);
        assign tbl_nbf[g]  = BFW'(BF);
        assign tbl_base[g] = CAW'(CB);
    end

    always_comb begin
        win_o  = '0;
        nbf_o  = '0;
        base_o = '0;
        if (int'(band_i) < NUM_BANDS) begin
            win_o  = tbl_win[band_i];
            nbf_o  = tbl_nbf[band_i];
            base_o = tbl_base[band_i];
        end
        even_o = ~win_o[0];
    end

    always_comb begin
        if (int'(band_i) < NUM_BANDS) begin
            a_r5_nbf_covers_half: assert (32'(nbf_o) == 32'(win_o) / 32'd2 + 32'd1);
        end
    end

endmodule

// File: rtl/cbseq_io_ctr.sv
module cbseq_io_ctr #(
    parameter int FRAME_LEN = 160,
    parameter int OUT_WORDS = 42,
    parameter int SAW       = 8,
    parameter int OAW       = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_i,
    input  logic           ld_step_i,
    input  logic           rd_step_i,
    output logic [SAW-1:0] ld_addr_o,
    output logic [OAW-1:0] rd_addr_o
);

    localparam logic [SAW-1:0] LD_MAX = SAW'(FRAME_LEN - 1);
    localparam logic [OAW-1:0] RD_MAX = OAW'(OUT_WORDS - 1);

    typedef struct packed {
        logic [SAW-1:0] ld;
        logic [OAW-1:0] rd;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (clr_i) begin
            ctr_d.ld = '0;
            ctr_d.rd = '0;
        end else begin
            if (ld_step_i) begin
                ctr_d.ld = (ctr_q.ld == LD_MAX) ? '0 : ctr_q.ld + 1'b1;
            end
            if (rd_step_i) begin
                ctr_d.rd = (ctr_q.rd == RD_MAX) ? '0 : ctr_q.rd + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign ld_addr_o = ctr_q.ld;
    assign rd_addr_o = ctr_q.rd;

    a_r2_load_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_step_i && !clr_i && ld_addr_o == LD_MAX) |=> ld_addr_o == '0);

    a_r3_unload_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step_i && !clr_i && rd_addr_o == RD_MAX) |=> rd_addr_o == '0);

    a_r2_load_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_step_i && !clr_i) |=> $stable(ld_addr_o));

endmodule

// File: rtl/cbseq_top.sv
module cbseq_top #(
    parameter int NUM_BANDS  = 21,
    parameter int FRAME_LEN  = 160,
    parameter int FLAT_BANDS = 5,
    parameter int SHRINK_NUM = 28,
    parameter int SHRINK_DEN = 33,
    parameter int PIPE_LAT   = 3,
    localparam int SAW       = $clog2(FRAME_LEN),
    localparam int NW        = $clog2(FRAME_LEN + 1),
    localparam int BFW       = $clog2(FRAME_LEN / 2 + 2),
    localparam int BW        = $clog2(NUM_BANDS),
    localparam int OUT_WORDS = 2 * NUM_BANDS,
    localparam int OAW       = $clog2(OUT_WORDS),
    localparam int ROM_TOTAL = cbseq_pkg::coef_base(NUM_BANDS, FRAME_LEN, FLAT_BANDS,
                                                    SHRINK_NUM, SHRINK_DEN),
    localparam int CAW       = $clog2(ROM_TOTAL),
    localparam int LTW       = $clog2(PIPE_LAT + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           ld_valid_i,
    input  logic           rd_req_i,
    output logic           busy_o,
    output logic           frame_done_o,
    output logic [SAW-1:0] smp_a_addr_o,
    output logic           smp_we_o,
    output logic           smp_a_en_o,
    output logic [SAW-1:0] smp_b_addr_o,
    output logic           smp_b_en_o,
    output logic [CAW-1:0] cos_addr_o,
    output logic [CAW-1:0] sin_addr_o,
    output logic           coef_en_o,
    output logic           band_first_o,
    output logic           band_last_o,
    output logic           even_o,
    output logic [BW-1:0]  band_o,
    output logic [OAW-1:0] out_addr_o,
    output logic           out_we_o,
    output logic           out_imag_o,
    output logic           out_rd_o
);

    import cbseq_pkg::*;

    localparam logic [BW-1:0]  LAST_BAND = BW'(NUM_BANDS - 1);
    localparam logic [LTW-1:0] LAT_END   = LTW'(PIPE_LAT - 1);

    typedef struct packed {
        mode_e          mode;
        logic [BW-1:0]  band;
        logic [BFW-1:0] bf;
        logic [LTW-1:0] lat;
        logic           done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [NW-1:0]  win;
    logic [BFW-1:0] nbf;
    logic           even_w;
    logic [CAW-1:0] base;
    logic [SAW-1:0] ld_addr;
    logic [OAW-1:0] rd_addr;
    logic           io_mode, run_mode, last_bf, pair_b;

    cbseq_band_table #(
        .NUM_BANDS (NUM_BANDS),
        .FRAME_LEN (FRAME_LEN),
        .FLAT_BANDS(FLAT_BANDS),
        .SHRINK_NUM(SHRINK_NUM),
        .SHRINK_DEN(SHRINK_DEN),
        .BW        (BW),
        .NW        (NW),
        .BFW       (BFW),
        .CAW       (CAW)
    ) band_tbl_i (
        .band_i(seq_q.band),
        .win_o (win),
        .nbf_o (nbf),
        .even_o(even_w),
        .base_o(base)
    );

    assign io_mode  = (seq_q.mode == M_IO);
    assign run_mode = (seq_q.mode == M_RUN);
    assign last_bf  = (seq_q.bf == nbf - BFW'(1));
    assign pair_b   = run_mode && (seq_q.bf != '0) && !(even_w && last_bf);

    cbseq_io_ctr #(
        .FRAME_LEN(FRAME_LEN),
        .OUT_WORDS(OUT_WORDS),
        .SAW      (SAW),
        .OAW      (OAW)
    ) io_ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (io_mode && start_i),
        .ld_step_i(io_mode && ld_valid_i),
        .rd_step_i(io_mode && rd_req_i),
        .ld_addr_o(ld_addr),
        .rd_addr_o(rd_addr)
    );

    // Next-state process
    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.mode)
            M_IO: begin
                if (start_i) begin
                    seq_d.mode = M_RUN;
                    seq_d.band = '0;
                    seq_d.bf   = '0;
                end
            end
            M_RUN: begin
                if (last_bf) begin
                    seq_d.mode = M_DRAIN;
                    seq_d.lat  = '0;
                end else begin
                    seq_d.bf = seq_q.bf + 1'b1;
                end
            end
            M_DRAIN: begin
                if (seq_q.lat == LAT_END) seq_d.mode = M_WRE;
                else                      seq_d.lat  = seq_q.lat + 1'b1;
            end
            M_WRE: seq_d.mode = M_WIM;
            M_WIM: begin
                if (seq_q.band == LAST_BAND) begin
                    seq_d.mode = M_IO;
                    seq_d.done = 1'b1;
                end else begin
                    seq_d.mode = M_RUN;
                    seq_d.band = seq_q.band + 1'b1;
                    seq_d.bf   = '0;
                end
            end
            default: seq_d.mode = M_IO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.mode <= M_IO;
        end else begin
            seq_q <= seq_d;
        end
    end

    // Output decode
    always_comb begin
        busy_o       = !io_mode;
        frame_done_o = seq_q.done;
        smp_we_o     = io_mode && ld_valid_i;
        out_rd_o     = io_mode && rd_req_i;
        smp_a_en_o   = run_mode;
        smp_a_addr_o = io_mode ? ld_addr : (run_mode ? SAW'(seq_q.bf) : '0);
        smp_b_en_o   = pair_b;
        smp_b_addr_o = pair_b ? SAW'(win - NW'(seq_q.bf)) : '0;
        coef_en_o    = run_mode;
        cos_addr_o   = run_mode ? base + (CAW'(seq_q.bf) << 1) : '0;
        sin_addr_o   = run_mode ? base + (CAW'(seq_q.bf) << 1) + CAW'(1) : '0;
        band_first_o = run_mode && (seq_q.bf == '0);
        band_last_o  = run_mode && last_bf;
        even_o       = even_w;
        band_o       = seq_q.band;
        out_we_o     = (seq_q.mode == M_WRE) || (seq_q.mode == M_WIM);
        out_imag_o   = (seq_q.mode == M_WIM);
        out_addr_o   = io_mode ? rd_addr
                               : (out_we_o ? OAW'({seq_q.band, out_imag_o}) : '0);
    end

    // R6: first sample address climbs by one inside a band
    a_r6_a_climbs: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_a_en_o && !band_first_o) |-> smp_a_addr_o == $past(smp_a_addr_o) + 1'b1);

    // R6: second sample address falls by one while pairs continue
    a_r6_b_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_b_en_o && $past(smp_b_en_o)) |-> smp_b_addr_o == $past(smp_b_addr_o) - 1'b1);

    a_r6_b_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        smp_b_en_o |-> 32'(smp_b_addr_o) < FRAME_LEN);

    a_r7_coef_step: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_en_o && !band_first_o) |-> cos_addr_o == $past(cos_addr_o) + CAW'(2));

    a_r9_imag_follows_real: assert property (@(posedge clk) disable iff (!rst_n)
        (out_we_o && !out_imag_o) |=> (out_we_o && out_imag_o
                                       && out_addr_o == $past(out_addr_o) + 1'b1));

    a_r4_band_order: assert property (@(posedge clk) disable iff (!rst_n)
        (band_first_o && $past(out_we_o)) |-> band_o == $past(band_o) + 1'b1);

    a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> (!busy_o && $past(out_we_o && out_imag_o)
                          && $past(band_o) == LAST_BAND));

    a_r11_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!smp_we_o && !out_rd_o));

    a_r8_marks_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (band_first_o && band_last_o) |-> 1'b0 == 1'b1 || nbf == BFW'(1));

endmodule

// File: tb/cbseq_top_tb_top.sv
module cbseq_top_tb_top;

    localparam int CLK_P  = 10;
    localparam int NB     = 21;
    localparam int FRAME  = 160;
    localparam int NFLAT  = 5;
    localparam int LAT    = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i, ld_valid_i, rd_req_i;
    logic        busy_o, frame_done_o, smp_we_o, smp_a_en_o, smp_b_en_o;
    logic        coef_en_o, band_first_o, band_last_o, even_o;
    logic        out_we_o, out_imag_o, out_rd_o;
    logic [7:0]  smp_a_addr_o, smp_b_addr_o;
    logic [10:0] cos_addr_o, sin_addr_o;
    logic [4:0]  band_o;
    logic [5:0]  out_addr_o;

    int total = 0;
    int bad   = 0;
    int n_tab [NB];
    int c_tab [NB];
    int o_tab [NB];

    always #(CLK_P / 2) clk = ~clk;

    cbseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ld_valid_i(ld_valid_i),
        .rd_req_i(rd_req_i), .busy_o(busy_o), .frame_done_o(frame_done_o),
        .smp_a_addr_o(smp_a_addr_o), .smp_we_o(smp_we_o), .smp_a_en_o(smp_a_en_o),
        .smp_b_addr_o(smp_b_addr_o), .smp_b_en_o(smp_b_en_o),
        .cos_addr_o(cos_addr_o), .sin_addr_o(sin_addr_o), .coef_en_o(coef_en_o),
        .band_first_o(band_first_o), .band_last_o(band_last_o), .even_o(even_o),
        .band_o(band_o), .out_addr_o(out_addr_o), .out_we_o(out_we_o),
        .out_imag_o(out_imag_o), .out_rd_o(out_rd_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary_and_end();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic check_run(input int b, input int j);
        int n, last, ben;
        n    = n_tab[b];
        last = c_tab[b] - 1;
        ben  = (j != 0 && !((n % 2 == 0) && j == last)) ? 1 : 0;
        chk("R4 busy", int'(busy_o), 1);
        chk("R4 band", int'(band_o), b);
        chk("R11 no load", int'(smp_we_o), 0);
        chk("R11 no unload", int'(out_rd_o), 0);
        chk("R6 a_en", int'(smp_a_en_o), 1);
        chk("R6 a_addr", int'(smp_a_addr_o), j);
        chk("R6 b_en", int'(smp_b_en_o), ben);
        chk("R6 b_addr", int'(smp_b_addr_o), ben ? n - j : 0);
        chk("R5 even", int'(even_o), (n % 2 == 0) ? 1 : 0);
        chk("R7 coef_en", int'(coef_en_o), 1);
        chk("R7 cos", int'(cos_addr_o), o_tab[b] + 2 * j);
        chk("R7 sin", int'(sin_addr_o), o_tab[b] + 2 * j + 1);
        chk("R8 first", int'(band_first_o), (j == 0) ? 1 : 0);
        chk("R8 last", int'(band_last_o), (j == last) ? 1 : 0);
        chk("R9 no write in run", int'(out_we_o), 0);
    endtask

    task automatic run_frame(input bit noisy);
        @(negedge clk);
        start_i = 1'b1; ld_valid_i = 1'b0; rd_req_i = 1'b0;
        #1 chk("R4 idle before edge", int'(busy_o), 0);
        for (int b = 0; b < NB; b++) begin
            for (int j = 0; j < c_tab[b]; j++) begin
                @(negedge clk);
                start_i = noisy; ld_valid_i = noisy; rd_req_i = noisy;
                #1 check_run(b, j);
            end
            for (int l = 0; l < LAT; l++) begin
                @(negedge clk);
                #1;
                chk("R9 drain a_en", int'(smp_a_en_o), 0);
                chk("R9 drain coef", int'(coef_en_o), 0);
                chk("R9 drain we", int'(out_we_o), 0);
                chk("R11 drain busy", int'(busy_o), 1);
            end
            @(negedge clk);
            #1;
            chk("R9 real we", int'(out_we_o), 1);
            chk("R9 real imag", int'(out_imag_o), 0);
            chk("R9 real addr", int'(out_addr_o), 2 * b);
            chk("R10 no early done", int'(frame_done_o), 0);
            @(negedge clk);
            if (b == NB - 1) start_i = 1'b0;
            #1;
            chk("R9 imag we", int'(out_we_o), 1);
            chk("R9 imag flag", int'(out_imag_o), 1);
            chk("R9 imag addr", int'(out_addr_o), 2 * b + 1);
            chk("R11 no unload in wb", int'(out_rd_o), 0);
        end
        @(negedge clk);
        #1;
        chk("R10 busy low", int'(busy_o), 0);
        chk("R10 done high", int'(frame_done_o), 1);
        chk("R11 unload served at done", int'(out_rd_o), int'(noisy));
        chk("R11 unload addr 0", int'(out_addr_o), 0);
        chk("R11 load served at done", int'(smp_we_o), int'(noisy));
        chk("R11 load addr 0", int'(smp_a_addr_o), 0);
        @(negedge clk);
        ld_valid_i = 1'b0; rd_req_i = 1'b0;
        #1;
        chk("R10 done one cycle", int'(frame_done_o), 0);
        chk("R3 unload step", int'(out_addr_o), noisy ? 1 : 0);
        chk("R2 load step", int'(smp_a_addr_o), noisy ? 1 : 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++;
        $display("FAIL watchdog expired");
        summary_and_end();
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            n_tab[b] = (b < NFLAT) ? FRAME : (n_tab[b - 1] * 28) / 33;
            c_tab[b] = n_tab[b] / 2 + 1;
            o_tab[b] = (b == 0) ? 0 : o_tab[b - 1] + 2 * c_tab[b - 1];
        end
        rst_n = 1'b0; start_i = 1'b0; ld_valid_i = 1'b0; rd_req_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 done", int'(frame_done_o), 0);
        chk("R1 we", int'(smp_we_o), 0);
        chk("R1 a_en", int'(smp_a_en_o), 0);
        chk("R1 coef_en", int'(coef_en_o), 0);
        chk("R1 out_we", int'(out_we_o), 0);
        chk("R1 a_addr", int'(smp_a_addr_o), 0);
        chk("R1 out_addr", int'(out_addr_o), 0);

        for (int k = 0; k < 165; k++) begin
            @(negedge clk);
            ld_valid_i = 1'b1;
            #1;
            chk("R2 load we", int'(smp_we_o), 1);
            chk("R2 load addr", int'(smp_a_addr_o), k % FRAME);
        end
        @(negedge clk);
        ld_valid_i = 1'b0;
        #1;
        chk("R2 no strobe", int'(smp_we_o), 0);
        chk("R2 addr held", int'(smp_a_addr_o), 165 % FRAME);

        for (int k = 0; k < 45; k++) begin
            @(negedge clk);
            rd_req_i = 1'b1;
            #1;
            chk("R3 unload rd", int'(out_rd_o), 1);
            chk("R3 unload addr", int'(out_addr_o), k % (2 * NB));
        end
        @(negedge clk);
        rd_req_i = 1'b0;
        #1;
        chk("R3 addr held", int'(out_addr_o), 45 % (2 * NB));

        run_frame(1'b1);
        run_frame(1'b0);
        summary_and_end();
    end

endmodule